// File: doc/BRIEF.md
# Ping-pong layer feature-map buffer

This block holds the feature maps of a layer-by-layer convolution engine in two identical on-chip memories (bank 0 and bank 1), so that intermediate maps never travel off-chip. Before the first layer a network start pulse opens a load phase. During the load phase, 16-bit beats from the off-chip stream are packed four at a time into 64-bit words, each holding sixteen 4-bit values, and written to bank 0 at consecutive addresses.

During each layer one bank is the input bank, read by the scheduler, and the other is the output bank, written by the output arrangement logic. When a layer finishes, the roles swap, so the bank that has just received results feeds the next layer. When the final layer finishes, the block streams a programmed number of words from the bank that has just been written back out as 16-bit beats and then pulses done. An access that names the wrong bank, or that comes outside a layer, is dropped and sets a sticky error flag.

Top module: `fmb_pingpong`

## Requirements
- R1: After reset, in_bank is 0, err is 0, rd_valid, unl_valid and unl_done are 0, and layer_busy is 0.
- R2: After net_start, each group of four accepted beats forms one word whose bits [15:0] hold the first beat and bits [63:48] the fourth. Successive words go to bank 0 at addresses 0, 1, 2 and so on.
- R3: While a layer runs (layer_busy = 1), rd_en with rd_bank equal to in_bank returns the word at rd_addr on rd_data, with rd_valid high, in the cycle after the request.
- R4: While a layer runs, wr_en with wr_bank not equal to in_bank stores wr_data at wr_addr. The word can be read back when that bank is the input bank of a later layer.
- R5: Each layer_done accepted during a layer inverts in_bank. net_start forces in_bank to 0 (bank 0 is the input bank).
- R6: A read that names the output bank during a layer gives no rd_valid and sets err.
- R7: A write that names the input bank during a layer leaves memory unchanged and sets err.
- R8: A read or write presented outside a running layer is dropped and sets err.
- R9: err stays set until the next net_start, which clears it.
- R10: layer_done with last_layer = 1 starts an unload of unl_words words, addresses 0 upward, from the bank that the final layer wrote. Each word is sent as four unl_valid beats, with bits [15:0] first.
- R11: unl_done pulses for one cycle, in the cycle right after the final beat. With unl_words = 0, it pulses without any beat.
- R12: Load beats presented outside the load phase are ignored and write nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| net_start | input | 1 | Start of a network: opens the load phase, clears role and error |
| ld_valid | input | 1 | Load beat valid |
| ld_data | input | 16 | Load beat, four 4-bit values, lowest nibble first |
| layer_start | input | 1 | Begin a layer |
| layer_done | input | 1 | End of the running layer |
| last_layer | input | 1 | Qualifies layer_done as the final layer |
| unl_words | input | 11 | Number of words to unload |
| rd_en | input | 1 | Scheduler read request |
| rd_bank | input | 1 | Bank the read targets |
| rd_addr | input | 10 | Read word address |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 64 | Read data |
| wr_en | input | 1 | Arrangement write request |
| wr_bank | input | 1 | Bank the write targets |
| wr_addr | input | 10 | Write word address |
| wr_data | input | 64 | Write data |
| unl_valid | output | 1 | Unload beat valid |
| unl_data | output | 16 | Unload beat |
| unl_done | output | 1 | Unload finished pulse |
| in_bank | output | 1 | Current input bank |
| layer_busy | output | 1 | A layer is running |
| err | output | 1 | Sticky wrong-role or out-of-layer access flag |

## Verification
A 16-word configuration is swept over every address across three layers, so that each bank serves as both input and output. This exposes a role swap that is missing or doubled: the reads would return the pattern of the wrong layer. Blocked writes to address 0 of the input bank and stray load beats after the load phase are both checked in a later layer through reads. A design that let either one through would return corrupted words at low addresses. The unload checks the beat order, the word count, the gap between words and the exact done cycle, including a zero-word unload. A count off by one, or a done pulse in the wrong cycle, would be caught.

// File: rtl/fmb_pkg.sv
package fmb_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_LOAD,
    PH_RUN,
    PH_GAP,
    PH_UNLOAD
  } phase_t;
endpackage

// File: rtl/fmb_bank.sv
module fmb_bank #(
  parameter int WORD_W = 64,
  parameter int DEPTH  = 1024,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] dout
);
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) dout <= mem[raddr];
  end
endmodule

// File: rtl/fmb_packer.sv
module fmb_packer #(
  parameter int BEAT_W = 16,
  parameter int WORD_W = 64,
  parameter int DEPTH  = 1024,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int BEATS  = WORD_W / BEAT_W,
  localparam int CNT_W  = $clog2(BEATS),
  localparam int ACC_W  = WORD_W - BEAT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              beat_valid,
  input  logic [BEAT_W-1:0] beat,
  output logic              word_valid,
  output logic [WORD_W-1:0] word,
  output logic [ADDR_W-1:0] addr
);
  logic [CNT_W-1:0] cnt;
  logic [ACC_W-1:0] acc;
  logic             last_beat;

  assign last_beat  = (cnt == CNT_W'(BEATS - 1));
  assign word_valid = beat_valid && last_beat;
  assign word       = {beat, acc};

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt  <= '0;
      addr <= '0;
    end else if (beat_valid) begin
      cnt <= last_beat ? '0 : cnt + 1'b1;
      if (last_beat) addr <= addr + 1'b1;
    end
  end

  generate
    if (ACC_W > BEAT_W) begin : g_shift
      always_ff @(posedge clk) begin
        if (beat_valid) acc <= {beat, acc[ACC_W-1:BEAT_W]};
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (beat_valid) acc <= beat;
      end
    end
  endgenerate

  // R2: every completed word advances the load address by one
  a_r2_addr_step: assert property (@(posedge clk) disable iff (rst)
    (word_valid && !clear) |=> addr == $past(addr) + 1'b1);
endmodule

// File: rtl/fmb_unloader.sv
module fmb_unloader #(
  parameter int WORD_W = 64,
  parameter int BEAT_W = 16,
  parameter int DEPTH  = 1024,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int BEATS  = WORD_W / BEAT_W,
  localparam int CNT_W  = $clog2(BEATS + 1),
  localparam int SEL_W  = $clog2(BEATS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              start,
  input  logic [ADDR_W:0]   words,
  input  logic [WORD_W-1:0] dout,
  output logic              re,
  output logic [ADDR_W-1:0] raddr,
  output logic              beat_valid,
  output logic [BEAT_W-1:0] beat,
  output logic              done
);
  logic             active;
  logic [CNT_W-1:0] cnt;
  logic [ADDR_W:0]  wcnt;
  logic [ADDR_W:0]  lim;
  logic [SEL_W-1:0] sel;

  assign sel   = SEL_W'(cnt - CNT_W'(1));
  assign re    = active && (cnt == '0) && (wcnt != lim);
  assign raddr = wcnt[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      active     <= 1'b0;
      cnt        <= '0;
      wcnt       <= '0;
      lim        <= '0;
      beat_valid <= 1'b0;
      beat       <= '0;
      done       <= 1'b0;
    end else begin
      beat_valid <= 1'b0;
      done       <= 1'b0;
      if (start) begin
        active <= 1'b1;
        cnt    <= '0;
        wcnt   <= '0;
        lim    <= words;
      end else if (active) begin
        if (cnt == '0) begin
          if (wcnt == lim) begin
            active <= 1'b0;
            done   <= 1'b1;
          end else begin
            cnt <= CNT_W'(1);
          end
        end else begin
          beat_valid <= 1'b1;
          beat       <= dout[sel*BEAT_W +: BEAT_W];
          if (cnt == CNT_W'(BEATS)) begin
            cnt  <= '0;
            wcnt <= wcnt + 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      end
    end
  end

  // R10: beats come only from an unload in progress
  a_r10_beat_in_unload: assert property (@(posedge clk) disable iff (rst)
    beat_valid |-> $past(active));
  // R11: done is a single-cycle pulse and never coincides with a beat
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |-> !beat_valid);
  a_r11_done_once: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/fmb_pingpong.sv
module fmb_pingpong
  import fmb_pkg::*;
#(
  parameter int WORD_W = 64,
  parameter int BEAT_W = 16,
  parameter int DEPTH  = 1024,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              net_start,
  input  logic              ld_valid,
  input  logic [BEAT_W-1:0] ld_data,
  input  logic              layer_start,
  input  logic              layer_done,
  input  logic              last_layer,
  input  logic [ADDR_W:0]   unl_words,
  input  logic              rd_en,
  input  logic              rd_bank,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic              wr_bank,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  output logic              unl_valid,
  output logic [BEAT_W-1:0] unl_data,
  output logic              unl_done,
  output logic              in_bank,
  output logic              layer_busy,
  output logic              err
);
  localparam int NBANK     = 2;
  localparam int LOAD_BANK = 0;

  phase_t phase;
  logic   in_bank_q, err_q, rd_valid_q, rd_bank_q;

  logic              in_run, in_load;
  logic              rd_ok, wr_ok, rd_bad, wr_bad;
  logic              ld_word_valid;
  logic [WORD_W-1:0] ld_word;
  logic [ADDR_W-1:0] ld_addr;
  logic              unl_start, unl_re;
  logic [ADDR_W-1:0] unl_raddr;

  logic [NBANK-1:0]  b_we, b_re;
  logic [ADDR_W-1:0] b_waddr [NBANK];
  logic [ADDR_W-1:0] b_raddr [NBANK];
  logic [WORD_W-1:0] b_wdata [NBANK];
  logic [WORD_W-1:0] b_dout  [NBANK];

  assign in_run  = (phase == PH_RUN);
  assign in_load = (phase == PH_LOAD);
  assign rd_ok   = rd_en && in_run && (rd_bank == in_bank_q);
  assign wr_ok   = wr_en && in_run && (wr_bank != in_bank_q);
  assign rd_bad  = rd_en && !rd_ok;
  assign wr_bad  = wr_en && !wr_ok;
  assign unl_start = in_run && layer_done && last_layer && !net_start;

  fmb_packer #(.BEAT_W(BEAT_W), .WORD_W(WORD_W), .DEPTH(DEPTH)) u_packer (
    .clk        (clk),
    .rst        (rst),
    .clear      (net_start),
    .beat_valid (ld_valid && in_load && !net_start),
    .beat       (ld_data),
    .word_valid (ld_word_valid),
    .word       (ld_word),
    .addr       (ld_addr)
  );

  generate
    for (genvar g = 0; g < NBANK; g++) begin : g_bank
      localparam bit SELF = (g == 1);
      assign b_we[g]    = (ld_word_valid && (g == LOAD_BANK)) ||
                          (wr_ok && (wr_bank == SELF));
      assign b_waddr[g] = ld_word_valid ? ld_addr : wr_addr;
      assign b_wdata[g] = ld_word_valid ? ld_word : wr_data;
      assign b_re[g]    = (rd_ok && (rd_bank == SELF)) ||
                          (unl_re && (in_bank_q == SELF));
      assign b_raddr[g] = unl_re ? unl_raddr : rd_addr;

      fmb_bank #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_bank (
        .clk   (clk),
        .we    (b_we[g]),
        .waddr (b_waddr[g]),
        .wdata (b_wdata[g]),
        .re    (b_re[g]),
        .raddr (b_raddr[g]),
        .dout  (b_dout[g])
      );
    end
  endgenerate

  fmb_unloader #(.WORD_W(WORD_W), .BEAT_W(BEAT_W), .DEPTH(DEPTH)) u_unload (
    .clk        (clk),
    .rst        (rst),
    .clear      (net_start),
    .start      (unl_start),
    .words      (unl_words),
    .dout       (b_dout[in_bank_q]),
    .re         (unl_re),
    .raddr      (unl_raddr),
    .beat_valid (unl_valid),
    .beat       (unl_data),
    .done       (unl_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      in_bank_q <= 1'b0;
      err_q     <= 1'b0;
    end else if (net_start) begin
      phase     <= PH_LOAD;
      in_bank_q <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      if (rd_bad || wr_bad) err_q <= 1'b1;
      case (phase)
        PH_LOAD, PH_GAP: if (layer_start) phase <= PH_RUN;
        PH_RUN: if (layer_done) begin
          in_bank_q <= ~in_bank_q;
          phase     <= last_layer ? PH_UNLOAD : PH_GAP;
        end
        PH_UNLOAD: if (unl_done) phase <= PH_IDLE;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid_q <= 1'b0;
      rd_bank_q  <= 1'b0;
    end else begin
      rd_valid_q <= rd_ok;
      if (rd_ok) rd_bank_q <= rd_bank;
    end
  end

  assign rd_valid   = rd_valid_q;
  assign rd_data    = b_dout[rd_bank_q];
  assign in_bank    = in_bank_q;
  assign layer_busy = in_run;
  assign err        = err_q;

  // R5: a finished layer swaps the roles of the banks
  a_r5_role_swap: assert property (@(posedge clk) disable iff (rst)
    (in_run && layer_done && !net_start) |=> in_bank_q != $past(in_bank_q));
  // R5, R9: a network start restores bank 0 as input and clears the error
  a_r5_start_role: assert property (@(posedge clk) disable iff (rst)
    net_start |=> (!in_bank_q && !err_q));
  // R6: a rejected read never produces data
  a_r6_read_block: assert property (@(posedge clk) disable iff (rst)
    rd_bad |=> !rd_valid_q);
  // R7: outside loading, the input bank is never written
  a_r7_input_safe: assert property (@(posedge clk) disable iff (rst)
    !in_load |-> !b_we[in_bank_q]);
  // R4: at most one bank is written per cycle
  a_r4_one_write: assert property (@(posedge clk) disable iff (rst)
    $onehot0(b_we));
  // R9: the error flag is sticky
  a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
    (err_q && !net_start) |=> err_q);
  // R12: no load word completes outside the load phase
  a_r12_no_stray_load: assert property (@(posedge clk) disable iff (rst)
    !in_load |-> !ld_word_valid);
endmodule

// File: tb/fmb_pingpong_bench.sv
module fmb_pingpong_bench;
  localparam int CLK_PERIOD = 10;
  localparam int D  = 16;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rst, net_start, ld_valid, layer_start, layer_done, last_layer;
  logic [15:0] ld_data;
  logic [AW:0] unl_words;
  logic rd_en, rd_bank, wr_en, wr_bank;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [63:0] wr_data, rd_data;
  logic rd_valid, unl_valid, unl_done, in_bank, layer_busy, err;
  logic [15:0] unl_data;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fmb_pingpong #(.WORD_W(64), .BEAT_W(16), .DEPTH(D)) u_fmb_pingpong (
    .clk(clk), .rst(rst), .net_start(net_start), .ld_valid(ld_valid),
    .ld_data(ld_data), .layer_start(layer_start), .layer_done(layer_done),
    .last_layer(last_layer), .unl_words(unl_words), .rd_en(rd_en),
    .rd_bank(rd_bank), .rd_addr(rd_addr), .rd_valid(rd_valid),
    .rd_data(rd_data), .wr_en(wr_en), .wr_bank(wr_bank), .wr_addr(wr_addr),
    .wr_data(wr_data), .unl_valid(unl_valid), .unl_data(unl_data),
    .unl_done(unl_done), .in_bank(in_bank), .layer_busy(layer_busy), .err(err)
  );

  function automatic logic [63:0] pat(int a, int salt);
    logic [63:0] r;
    for (int i = 0; i < 16; i++) r[4*i +: 4] = 4'(a*3 + i*5 + salt*7);
    return r;
  endfunction

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic pulse_layer_start();
    layer_start = 1'b1; tick(); layer_start = 1'b0;
  endtask

  // Read every address of a bank; expected salt picked per address
  task automatic read_sweep(logic bank, int lo_salt, int hi_salt, int split, string req);
    for (int a = 0; a <= D; a++) begin
      if (a > 0) begin
        check(rd_valid === 1'b1, req, 64'(rd_valid), 64'd1);
        check(rd_data === pat(a-1, (a-1 < split) ? lo_salt : hi_salt), req,
              rd_data, pat(a-1, (a-1 < split) ? lo_salt : hi_salt));
      end
      rd_en   = (a < D);
      rd_bank = bank;
      rd_addr = AW'(a);
      tick();
    end
    rd_en = 1'b0;
  endtask

  task automatic write_sweep(logic bank, int first, int salt);
    for (int a = first; a < D; a++) begin
      wr_en = 1'b1; wr_bank = bank; wr_addr = AW'(a); wr_data = pat(a, salt);
      tick();
    end
    wr_en = 1'b0;
  endtask

  task automatic stray_beats();
    for (int k = 0; k < 32; k++) begin
      ld_valid = 1'b1; ld_data = 16'hDEAD ^ 16'(k);
      tick();
    end
    ld_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int beats, last_cyc;
    bit seen;
    rst = 1; net_start = 0; ld_valid = 0; ld_data = 0; layer_start = 0;
    layer_done = 0; last_layer = 0; unl_words = 0; rd_en = 0; rd_bank = 0;
    rd_addr = 0; wr_en = 0; wr_bank = 0; wr_addr = 0; wr_data = 0;
    repeat (3) tick();
    rst = 0; tick();
    // R1 reset state
    check(in_bank === 1'b0 && err === 1'b0, "R1 role/err", {in_bank, err}, 0);
    check(rd_valid === 0 && unl_valid === 0 && unl_done === 0 && layer_busy === 0,
          "R1 outputs", {rd_valid, unl_valid, unl_done, layer_busy}, 0);

    net_start = 1; tick(); net_start = 0;
    // R2 load sweep into bank 0
    for (int a = 0; a < D; a++) begin
      for (int k = 0; k < 4; k++) begin
        ld_valid = 1'b1; ld_data = pat(a, 1)[16*k +: 16];
        tick();
      end
    end
    ld_valid = 1'b0;

    pulse_layer_start();
    check(layer_busy === 1'b1, "R3 layer busy", 64'(layer_busy), 1);
    read_sweep(1'b0, 1, 1, D, "R2 R3 layer1 read");
    write_sweep(1'b1, 0, 2);
    stray_beats();
    check(err === 1'b0, "R6 R7 no false error", 64'(err), 0);
    // R7 write to input bank is blocked
    wr_en = 1; wr_bank = 0; wr_addr = 0; wr_data = '1; tick(); wr_en = 0;
    check(err === 1'b1, "R7 err on wrong write", 64'(err), 1);
    // R6 read from output bank is blocked
    rd_en = 1; rd_bank = 1; rd_addr = 0; tick(); rd_en = 0;
    check(rd_valid === 1'b0, "R6 no data", 64'(rd_valid), 0);
    layer_done = 1; tick(); layer_done = 0;
    check(in_bank === 1'b1 && layer_busy === 1'b0, "R5 swap after layer1",
          {in_bank, layer_busy}, 2);
    // R8 access between layers
    rd_en = 1; rd_bank = 1; rd_addr = 2; tick(); rd_en = 0;
    check(rd_valid === 1'b0, "R8 read between layers", 64'(rd_valid), 0);
    check(err === 1'b1, "R9 err held", 64'(err), 1);
    stray_beats();

    pulse_layer_start();
    read_sweep(1'b1, 2, 2, D, "R4 layer2 read");
    write_sweep(1'b0, 8, 3);
    layer_done = 1; tick(); layer_done = 0;
    check(in_bank === 1'b0, "R5 swap after layer2", 64'(in_bank), 0);

    pulse_layer_start();
    read_sweep(1'b0, 1, 3, 8, "R4 R7 R12 layer3 read");
    write_sweep(1'b1, 0, 4);
    layer_done = 1; last_layer = 1; unl_words = 5; tick();
    layer_done = 0; last_layer = 0;
    check(in_bank === 1'b1, "R5 swap after final layer", 64'(in_bank), 1);

    // R10 R11 unload
    beats = 0; last_cyc = -100; seen = 0;
    for (int cyc = 0; cyc < 100 && !seen; cyc++) begin
      if (unl_valid) begin
        check(unl_data === pat(beats/4, 4)[16*(beats%4) +: 16], "R10 beat",
              64'(unl_data), 64'(pat(beats/4, 4)[16*(beats%4) +: 16]));
        beats++; last_cyc = cyc;
      end
      if (unl_done) begin
        seen = 1;
        check(beats == 20, "R10 beat count", 64'(beats), 20);
        check(cyc == last_cyc + 1, "R11 done timing", 64'(cyc - last_cyc), 1);
      end
      tick();
    end
    check(seen, "R11 done seen", 64'(seen), 1);

    net_start = 1; tick(); net_start = 0;
    check(in_bank === 1'b0 && err === 1'b0, "R5 R9 restart clears",
          {in_bank, err}, 0);

    // R11 zero-word unload
    pulse_layer_start();
    layer_done = 1; last_layer = 1; unl_words = 0; tick();
    layer_done = 0; last_layer = 0;
    beats = 0; seen = 0;
    for (int cyc = 0; cyc < 4; cyc++) begin
      if (unl_valid) beats++;
      if (unl_done) seen = 1;
      tick();
    end
    check(seen && beats == 0, "R11 zero-word unload", {seen, 32'(beats)}, 64'h1_0000_0000);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule